// File: doc/BRIEF.md
# Receive Frame Size Check and Statistics

This block sits at the end of a receive path. When a frame has been fully received, a one-cycle completion strobe presents its length (without the 4-byte frame check sequence), its length including the check sequence, and the destination class chosen by the address filter. The block decides whether the frame is too long and must be dropped, and it updates a bank of statistics counters.

The oversize limit depends on two control bits. One enables long frames, which raises the limit from the standard 1518 bytes to 16380 bytes. The other stores bad frames, which disables the oversize check entirely. A dropped frame only bumps the oversize counter. An accepted frame is sorted into one of six size bins. It also counts as a received packet and as a good packet, may count as broadcast or multicast, and adds its length plus 4 to two 64-bit octet counters. Every counter stops at its all-ones value. A read through the register port returns a counter and clears it.

Top module: `rx_size_stats`

## Requirements
- R1: A frame is oversize when `keep_bad` is 0 and its length exceeds 16380, or when it exceeds 1518 with `long_pkt_en` at 0. `drop_flag` is high for exactly the cycle after a strobe that carried an oversize frame, and low otherwise.
- R2: An oversize frame increments the oversize counter (select 0) and changes no other counter.
- R3: An accepted frame increments one size bin chosen by `frame_len_fcs`: select 1 for exactly 64, 2 for 65..127, 3 for 128..255, 4 for 256..511, 5 for 512..1023, and 6 for 1024 and above. A value below 64 increments no bin.
- R4: Every accepted frame increments both the total-packet counter (select 7) and the good-packet counter (select 8).
- R5: For an accepted frame, `pkt_kind` 2'b10 (broadcast) increments select 9 and `pkt_kind` 2'b01 (multicast) increments select 10. 2'b00 (unicast) increments neither.
- R6: Every accepted frame adds `frame_len` + 4 to the total-octet counter (low half at select 11, high half at 12) and to the good-octet counter (low 13, high 14).
- R7: Every counter stops at its all-ones value and never wraps.
- R8: With `rd_en` high, `rd_data` shows the selected value from the next cycle on and holds it until the next read. A read clears the selected packet counter. Reading an octet high half (12 or 14) clears that whole 64-bit counter; reading a low half clears nothing. When a frame updates a counter in the same cycle as the read that clears it, the counter restarts from the increment.
- R9: After reset all counters, `rd_data` and `drop_flag` are zero. Selects above 14 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: a received frame is complete |
| frame_len | input | LEN_W | Frame length in bytes without check sequence |
| frame_len_fcs | input | LEN_W | Frame length in bytes including check sequence, used for binning |
| pkt_kind | input | 2 | Destination class: 00 unicast, 01 multicast, 10 broadcast |
| long_pkt_en | input | 1 | Raise the size limit to 16380 bytes |
| keep_bad | input | 1 | Disable the oversize check |
| rd_en | input | 1 | Read strobe for the counter bank |
| rd_sel | input | SEL_W | Counter select |
| rd_data | output | 32 | Registered read data |
| drop_flag | output | 1 | Frame of the previous cycle is oversize and must be dropped |

## Verification
Every counter is also cleared by the read that exposes it, so a wrong increment or a wrong bin choice shows up as a miscompare on the very next read after the offending frame. The bench therefore reads the whole bank after each single frame. A wrong limit comparison appears on `drop_flag` one cycle after the strobe, and again on the oversize counter at the following read. A counter that wraps instead of holding only shows after many frames, so narrow counter widths are used to reach the ceiling within a few hundred frames.

// File: rtl/rx_stats_pkg.sv
package rx_stats_pkg;

  localparam int NUM_BINS = 6;
  localparam int NUM_CNT  = 11;
  localparam int IDX_OVS  = 0;
  localparam int IDX_BIN  = 1;
  localparam int IDX_TOT  = 7;
  localparam int IDX_GOOD = 8;
  localparam int IDX_BC   = 9;
  localparam int IDX_MC   = 10;
  localparam int SEL_TOT_LO  = 11;
  localparam int SEL_TOT_HI  = 12;
  localparam int SEL_GOOD_LO = 13;
  localparam int SEL_GOOD_HI = 14;
  localparam int FCS_BYTES   = 4;

  typedef enum logic [1:0] {
    KIND_UNI   = 2'b00,
    KIND_MULTI = 2'b01,
    KIND_BCAST = 2'b10
  } pkt_kind_e;

  function automatic int bin_lo(input int k);
    if (k == 0) return 64;
    if (k == 1) return 65;
    return 64 << (k - 1);
  endfunction

  function automatic int bin_hi(input int k);
    if (k == 0) return 64;
    if (k == NUM_BINS - 1) return 32'h7fff_ffff;
    return (128 << (k - 1)) - 1;
  endfunction

endpackage

// File: rtl/rx_sat_counter.sv
module rx_sat_counter #(
  parameter int W  = 32,
  parameter int AW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add_en,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  q
);

  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = clr ? '0 : q;
    sum  = {1'b0, base} + (W+1)'(amt);
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (add_en)
      q <= sum[W] ? '1 : sum[W-1:0];
    else
      q <= base;
  end

endmodule

// File: rtl/rx_frame_class.sv
module rx_frame_class
  import rx_stats_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int STD_MAX   = 1518,
  parameter int JUMBO_MAX = 16380
) (
  input  logic [LEN_W-1:0]    len,
  input  logic [LEN_W-1:0]    len_fcs,
  input  logic                long_en,
  input  logic                keep_bad,
  output logic                oversize,
  output logic [NUM_BINS-1:0] bin_hit
);

  logic over_jumbo, over_std;

  always_comb begin
    over_jumbo = 32'(len) > JUMBO_MAX;
    over_std   = 32'(len) > STD_MAX;
    oversize   = !keep_bad && (over_jumbo || (over_std && !long_en));
  end

  for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
    assign bin_hit[k] = (32'(len_fcs) >= bin_lo(k)) && (32'(len_fcs) <= bin_hi(k));
  end

endmodule

// File: rtl/rx_size_stats.sv
module rx_size_stats
  import rx_stats_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 32,
  parameter int OCT_W     = 64,
  parameter int SEL_W     = 5,
  parameter int STD_MAX   = 1518,
  parameter int JUMBO_MAX = 16380
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_done,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [LEN_W-1:0] frame_len_fcs,
  input  logic [1:0]       pkt_kind,
  input  logic             long_pkt_en,
  input  logic             keep_bad,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [31:0]      rd_data,
  output logic             drop_flag
);

  localparam int AMT_W = LEN_W + 1;

  logic                           oversize;
  logic [NUM_BINS-1:0]            bin_hit;
  logic                           accepted;
  logic [NUM_CNT-1:0]             inc;
  logic [NUM_CNT-1:0]             clr;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [AMT_W-1:0]               oct_amt;
  logic                           tot_clr, good_clr;
  logic [OCT_W-1:0]               tot_oct, good_oct;
  logic [63:0]                    tot64, good64;
  logic [31:0]                    rd_next;
  logic [CNT_W-1:0]               ovs_cnt;

  rx_frame_class #(
    .LEN_W(LEN_W), .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX)
  ) class_i (
    .len(frame_len), .len_fcs(frame_len_fcs), .long_en(long_pkt_en),
    .keep_bad(keep_bad), .oversize(oversize), .bin_hit(bin_hit)
  );

  always_comb begin
    accepted          = frame_done && !oversize;
    inc               = '0;
    inc[IDX_OVS]      = frame_done && oversize;
    inc[IDX_TOT]      = accepted;
    inc[IDX_GOOD]     = accepted;
    inc[IDX_BC]       = accepted && (pkt_kind == KIND_BCAST);
    inc[IDX_MC]       = accepted && (pkt_kind == KIND_MULTI);
    for (int b = 0; b < NUM_BINS; b++)
      inc[IDX_BIN + b] = accepted && bin_hit[b];
    oct_amt  = AMT_W'(frame_len) + AMT_W'(FCS_BYTES);
    tot_clr  = rd_en && (32'(rd_sel) == SEL_TOT_HI);
    good_clr = rd_en && (32'(rd_sel) == SEL_GOOD_HI);
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign clr[k] = rd_en && (32'(rd_sel) == k);
    rx_sat_counter #(.W(CNT_W), .AW(1)) cnt_i (
      .clk(clk), .rst(rst), .clr(clr[k]), .add_en(inc[k]),
      .amt(1'b1), .q(cnt_q[k])
    );
  end

  rx_sat_counter #(.W(OCT_W), .AW(AMT_W)) tot_oct_i (
    .clk(clk), .rst(rst), .clr(tot_clr), .add_en(accepted),
    .amt(oct_amt), .q(tot_oct)
  );

  rx_sat_counter #(.W(OCT_W), .AW(AMT_W)) good_oct_i (
    .clk(clk), .rst(rst), .clr(good_clr), .add_en(accepted),
    .amt(oct_amt), .q(good_oct)
  );

  always_comb begin
    tot64   = 64'(tot_oct);
    good64  = 64'(good_oct);
    ovs_cnt = cnt_q[IDX_OVS];
    rd_next = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (32'(rd_sel) == k) rd_next = 32'(cnt_q[k]);
    case (32'(rd_sel))
      SEL_TOT_LO:  rd_next = tot64[31:0];
      SEL_TOT_HI:  rd_next = tot64[63:32];
      SEL_GOOD_LO: rd_next = good64[31:0];
      SEL_GOOD_HI: rd_next = good64[63:32];
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      drop_flag <= 1'b0;
    end else begin
      drop_flag <= frame_done && oversize;
      if (rd_en) rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/rx_size_stats_chk.sv
module rx_size_stats_chk #(
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 32,
  parameter int OCT_W     = 64,
  parameter int JUMBO_MAX = 16380
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_done,
  input logic [LEN_W-1:0] frame_len,
  input logic             keep_bad,
  input logic             drop_flag,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic [CNT_W-1:0] ovs_cnt,
  input logic             ovs_clr,
  input logic [OCT_W-1:0] good_oct,
  input logic             good_clr
);

  assert_drop_cause_R1: assert property (@(posedge clk) disable iff (rst)
    drop_flag |-> ($past(frame_done) && !$past(keep_bad)));

  assert_jumbo_drop_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !keep_bad && (32'(frame_len) > JUMBO_MAX)) |=> drop_flag);

  assert_ovs_count_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !keep_bad && (32'(frame_len) > JUMBO_MAX) && !ovs_clr && (ovs_cnt != '1))
      |=> (ovs_cnt == CNT_W'($past(ovs_cnt) + 1'b1)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (ovs_cnt < $past(ovs_cnt)) |-> $past(ovs_clr));

  assert_oct_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (good_oct < $past(good_oct)) |-> $past(good_clr));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));

endmodule

bind rx_size_stats rx_size_stats_chk #(
  .LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .JUMBO_MAX(JUMBO_MAX)
) chk_i (
  .clk(clk), .rst(rst), .frame_done(frame_done), .frame_len(frame_len),
  .keep_bad(keep_bad), .drop_flag(drop_flag), .rd_en(rd_en), .rd_data(rd_data),
  .ovs_cnt(ovs_cnt), .ovs_clr(clr[0]), .good_oct(good_oct), .good_clr(good_clr)
);

// File: tb/rx_size_stats_tb_top.sv
module rx_size_stats_tb_top;

  localparam int LEN_W = 16;
  localparam int CNT_W = 8;
  localparam int OCT_W = 20;
  localparam int SEL_W = 5;
  localparam int NV    = 16;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] fcs;
    logic [1:0]  kind;
    logic        lpe;
    logic        sbp;
    logic        drop;
    logic [2:0]  bin;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{16'd56,    16'd60,    2'b00, 1'b0, 1'b0, 1'b0, 3'd0},
    '{16'd60,    16'd64,    2'b10, 1'b0, 1'b0, 1'b0, 3'd1},
    '{16'd61,    16'd65,    2'b01, 1'b0, 1'b0, 1'b0, 3'd2},
    '{16'd123,   16'd127,   2'b00, 1'b0, 1'b0, 1'b0, 3'd2},
    '{16'd124,   16'd128,   2'b00, 1'b0, 1'b0, 1'b0, 3'd3},
    '{16'd252,   16'd256,   2'b01, 1'b0, 1'b0, 1'b0, 3'd4},
    '{16'd508,   16'd512,   2'b10, 1'b0, 1'b0, 1'b0, 3'd5},
    '{16'd1019,  16'd1023,  2'b00, 1'b0, 1'b0, 1'b0, 3'd5},
    '{16'd1020,  16'd1024,  2'b00, 1'b0, 1'b0, 1'b0, 3'd6},
    '{16'd1518,  16'd1522,  2'b00, 1'b0, 1'b0, 1'b0, 3'd6},
    '{16'd1519,  16'd1523,  2'b01, 1'b0, 1'b0, 1'b1, 3'd0},
    '{16'd1519,  16'd1523,  2'b01, 1'b1, 1'b0, 1'b0, 3'd6},
    '{16'd16380, 16'd16384, 2'b10, 1'b1, 1'b0, 1'b0, 3'd6},
    '{16'd16381, 16'd16385, 2'b10, 1'b1, 1'b0, 1'b1, 3'd0},
    '{16'd16381, 16'd16385, 2'b00, 1'b1, 1'b1, 1'b0, 3'd6},
    '{16'd3000,  16'd3004,  2'b01, 1'b0, 1'b1, 1'b0, 3'd6}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_done = 1'b0;
  logic [LEN_W-1:0] frame_len = '0;
  logic [LEN_W-1:0] frame_len_fcs = '0;
  logic [1:0]       pkt_kind = 2'b00;
  logic             long_pkt_en = 1'b0;
  logic             keep_bad = 1'b0;
  logic             rd_en = 1'b0;
  logic [SEL_W-1:0] rd_sel = '0;
  logic [31:0]      rd_data;
  logic             drop_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rx_size_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_len(frame_len),
    .frame_len_fcs(frame_len_fcs), .pkt_kind(pkt_kind), .long_pkt_en(long_pkt_en),
    .keep_bad(keep_bad), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .drop_flag(drop_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input int len, input int fcs, input logic [1:0] kind,
                      input logic lpe, input logic sbp);
    @(negedge clk);
    frame_len = LEN_W'(len); frame_len_fcs = LEN_W'(fcs);
    pkt_kind = kind; long_pkt_en = lpe; keep_bad = sbp; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic rd(input int sel, output logic [31:0] val);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = SEL_W'(sel);
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  function automatic string sel_req(input int s);
    if (s == 0) return "R2 oversize count";
    if (s <= 6) return "R3 size bin";
    if (s <= 8) return "R4 packet count";
    if (s <= 10) return "R5 class count";
    return "R6 octet count";
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    check("R9 drop_flag after reset", 32'(drop_flag), 0);
    check("R9 rd_data after reset", rd_data, 0);
    for (int s = 0; s < 15; s++) begin
      rd(s, v);
      check("R9 counter after reset", v, 0);
    end

    // table walk: one frame, then read and clear the whole bank
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].len, VECS[i].fcs, VECS[i].kind, VECS[i].lpe, VECS[i].sbp);
      check("R1 drop_flag", 32'(drop_flag), 32'(VECS[i].drop));
      for (int s = 0; s < 15; s++) begin
        rd(s, v);
        exp = 0;
        if (s == 0) exp = 32'(VECS[i].drop);
        else if (!VECS[i].drop) begin
          if (s <= 6) exp = (32'(VECS[i].bin) == s) ? 1 : 0;
          else if (s <= 8) exp = 1;
          else if (s == 9) exp = (VECS[i].kind == 2'b10) ? 1 : 0;
          else if (s == 10) exp = (VECS[i].kind == 2'b01) ? 1 : 0;
          else if (s == 11 || s == 13) exp = 32'(VECS[i].len) + 4;
        end
        check(sel_req(s), v, exp);
      end
    end

    // R1: drop_flag is a single-cycle pulse
    send(2000, 2004, 2'b00, 1'b0, 1'b0);
    check("R1 drop pulse", 32'(drop_flag), 1);
    @(negedge clk);
    check("R1 drop pulse ends", 32'(drop_flag), 0);
    rd(0, v);
    check("R2 oversize count", v, 1);

    // R7: saturation of packet counters
    for (int i = 0; i < 260; i++) send(60, 64, 2'b10, 1'b0, 1'b0);
    rd(7, v);  check("R7 total packets hold", v, 255);
    rd(1, v);  check("R7 bin hold", v, 255);
    rd(9, v);  check("R7 broadcast hold", v, 255);
    rd(7, v);  check("R8 cleared after read", v, 0);

    // R7: saturation of octet counters (260*64 + 70*16384 exceeds 20 bits)
    for (int i = 0; i < 70; i++) send(16380, 16384, 2'b00, 1'b1, 1'b0);
    rd(13, v); check("R7 good octets hold", v, 32'hFFFFF);
    rd(13, v); check("R8 low read keeps value", v, 32'hFFFFF);
    rd(14, v); check("R8 high half", v, 0);
    rd(13, v); check("R8 high read clears", v, 0);
    rd(11, v); check("R7 total octets hold", v, 32'hFFFFF);
    rd(12, v); check("R8 high half", v, 0);
    rd(11, v); check("R8 high read clears", v, 0);

    // R8: read and increment of the same counter in one cycle
    for (int s = 0; s < 11; s++) rd(s, v);
    send(100, 104, 2'b00, 1'b0, 1'b0);
    send(100, 104, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    frame_len = 16'd100; frame_len_fcs = 16'd104; pkt_kind = 2'b00;
    long_pkt_en = 1'b0; keep_bad = 1'b0; frame_done = 1'b1;
    rd_en = 1'b1; rd_sel = 5'd8;
    @(negedge clk);
    frame_done = 1'b0; rd_en = 1'b0;
    check("R8 read returns old value", rd_data, 2);
    rd(8, v);  check("R8 restart from increment", v, 1);

    // R8: rd_data holds without a read strobe
    repeat (3) @(negedge clk);
    check("R8 rd_data holds", rd_data, 1);

    // R9: unmapped select
    rd(20, v); check("R9 unmapped select", v, 0);

    summary();
  end

endmodule